// File: doc/BRIEF.md
# Address-Dependent Wait-State Word Memory

This block is a word-addressed storage array that answers each request after a number of wait cycles set by the request address. A requester raises `req` together with an address, a direction bit and write data, and keeps all of them steady until `ready` pulses. The block remembers the last request it took as new. A request with a different address, a different direction, or (for a write) different data loads a countdown equal to the address modulo 3. The access completes on the first evaluated cycle in which that countdown is zero. A read then updates the registered `rdata`, and a write stores `wdata`.

The remaining wait is held as the state of a small machine with three states. `WT_NONE` means no wait is left, so the next evaluated cycle completes. `WT_ONE` and `WT_TWO` mean one or two stall cycles remain. The state moves along these transitions:
- *complete*: `WT_NONE` to `WT_NONE`, with a grant.
- *step*: `WT_TWO` to `WT_ONE`, and `WT_ONE` to `WT_NONE`.
- *reload*: a new request replaces the current state with the residue of its address.
- *fault*: any state goes to `WT_NONE` when the address is out of range.
- *hold*: the state is kept on any cycle without evaluation.

Addresses at or above the configured capacity raise `addr_err` and never complete. A preload port writes words directly while it is active. Capacity is a parameter; 65536 words is the full configuration.

Top module: `wait_state_mem`

## Requirements
- R1: After reset `ready`, `addr_err` and `rdata` are 0, and the first request is always treated as new.
- R2: A new in-range request at address A raises `ready` after exactly (A mod 3)+1 rising edges, counting the edge that first samples it; `ready` is 0 at every sample before that.
- R3: A request is new when its address differs from the last new request, when its direction differs, or when it is a write whose data differs. A new request reloads the countdown, including one that arrives during a wait. A repeated identical request completes with no wait.
- R4: While a request is held after completing, `ready` is 1 after every edge; `ready` is never high after an edge that did not complete an access.
- R5: A completing read (`we`=0) places the stored word on `rdata` in the same cycle that `ready` rises.
- R6: A completing write (`we`=1) stores `wdata` at the address, and a later read returns it.
- R7: `rdata` changes only on a completing read; writes, idle cycles and stalls leave it unchanged.
- R8: A request whose address is at or above `MEM_WORDS` raises `addr_err` after each edge it is sampled at. It never raises `ready` and changes no stored word.
- R9: While `init_en` is 1, `init_data` is written to `init_addr` at each edge, and `req` is ignored: `ready` stays 0 and the countdown and last-request record stay as they are.
- R10: With `req` at 0, no evaluation takes place, so `ready` is 0 and the remaining wait and last-request record are kept. Reasserting the same request resumes the countdown rather than restarting it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| init_en | input | 1 | Preload write strobe; blocks requests |
| init_addr | input | IDX_W | Preload word index |
| init_data | input | DATA_W | Preload word |
| req | input | 1 | Request held until `ready` |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | ADDR_W | Word address of the request |
| wdata | input | DATA_W | Write data |
| ready | output | 1 | Access completed at the last edge |
| rdata | output | DATA_W | Last word read, registered |
| addr_err | output | 1 | Out-of-range address seen at the last edge |

## Verification
The bench builds the block with `MEM_WORDS`=64, `ADDR_W`=8 and `DATA_W`=16. An 8-bit address can name words past the 64-word store, so the fault path can be reached, including an address whose low bits alias a real word. The small store is preloaded in 64 cycles through the preload port, and every residue modulo 3 (including the top word, 63) is exercised with known contents.

// File: rtl/wait_state_mem_pkg.sv
package wait_state_mem_pkg;

    typedef enum logic [1:0] {
        WT_NONE = 2'd0,
        WT_ONE  = 2'd1,
        WT_TWO  = 2'd2
    } wait_e;

    function automatic wait_e wait_of(input logic [1:0] residue);
        unique case (residue)
            2'd1:    return WT_ONE;
            2'd2:    return WT_TWO;
            default: return WT_NONE;
        endcase
    endfunction

endpackage

// File: rtl/wsm_req_tracker.sv
module wsm_req_tracker #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              eval,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output logic              is_new
);
    logic              seen_q;
    logic [ADDR_W-1:0] last_addr_q;
    logic              last_we_q;
    logic [DATA_W-1:0] last_wdata_q;

    always_comb begin
        is_new = !seen_q
              || (addr != last_addr_q)
              || (we != last_we_q)
              || (we && (wdata != last_wdata_q));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q       <= 1'b0;
            last_addr_q  <= '0;
            last_we_q    <= 1'b0;
            last_wdata_q <= '0;
        end else if (eval && is_new) begin
            seen_q       <= 1'b1;
            last_addr_q  <= addr;
            last_we_q    <= we;
            last_wdata_q <= wdata;
        end
    end

    AST_REPEAT_NOT_NEW: assert property (@(posedge clk) disable iff (!rst_n)
        (eval && $past(rst_n) && $past(eval && is_new)
            && $stable(addr) && $stable(we) && $stable(wdata)) |-> !is_new); // R3

endmodule

// File: rtl/wsm_wait_fsm.sv
module wsm_wait_fsm
    import wait_state_mem_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       eval,
    input  logic       is_new,
    input  logic [1:0] residue,
    input  logic       bad_addr,
    output logic       grant
);
    wait_e cur_q, nxt, eff;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= WT_NONE;
        else        cur_q <= nxt;
    end

    always_comb begin
        eff = is_new ? wait_of(residue) : cur_q;
        nxt = cur_q;
        if (eval) begin
            if (bad_addr) begin
                nxt = WT_NONE;
            end else begin
                unique case (eff)
                    WT_NONE: nxt = WT_NONE;
                    WT_ONE:  nxt = WT_NONE;
                    WT_TWO:  nxt = WT_ONE;
                    default: nxt = WT_NONE;
                endcase
            end
        end
    end

    always_comb begin
        grant = eval && !bad_addr && (eff == WT_NONE);
    end

    AST_RELOAD_TWO: assert property (@(posedge clk) disable iff (!rst_n)
        (eval && !bad_addr && is_new && residue == 2'd2) |=> (cur_q == WT_ONE)); // R2

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !eval |=> $stable(cur_q)); // R10

endmodule

// File: rtl/wsm_word_store.sv
module wsm_word_store #(
    parameter int MEM_WORDS = 1024,
    parameter int DATA_W    = 32,
    localparam int IDX_W    = $clog2(MEM_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] mem [MEM_WORDS];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_idx] <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= mem[rd_idx];
    end

endmodule

// File: rtl/wait_state_mem.sv
module wait_state_mem #(
    parameter int MEM_WORDS = 1024,
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 32,
    localparam int IDX_W    = $clog2(MEM_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init_en,
    input  logic [IDX_W-1:0]  init_addr,
    input  logic [DATA_W-1:0] init_data,
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              ready,
    output logic [DATA_W-1:0] rdata,
    output logic              addr_err
);
    localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(MEM_WORDS);

    logic             eval, in_range, is_new, grant;
    logic [1:0]       residue;
    logic             st_wr_en;
    logic [IDX_W-1:0] st_wr_idx;
    logic [DATA_W-1:0] st_wr_data;

    always_comb begin
        eval     = req && !init_en;
        in_range = ({1'b0, addr} < LIMIT);
        residue  = 2'(addr % ADDR_W'(3));
    end

    wsm_req_tracker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_track (
        .clk    (clk),
        .rst_n  (rst_n),
        .eval   (eval),
        .addr   (addr),
        .we     (we),
        .wdata  (wdata),
        .is_new (is_new)
    );

    wsm_wait_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .eval     (eval),
        .is_new   (is_new),
        .residue  (residue),
        .bad_addr (!in_range),
        .grant    (grant)
    );

    always_comb begin
        st_wr_en   = init_en || (grant && we);
        st_wr_idx  = init_en ? init_addr : addr[IDX_W-1:0];
        st_wr_data = init_en ? init_data : wdata;
    end

    wsm_word_store #(.MEM_WORDS(MEM_WORDS), .DATA_W(DATA_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (st_wr_en),
        .wr_idx  (st_wr_idx),
        .wr_data (st_wr_data),
        .rd_en   (grant && !we),
        .rd_idx  (addr[IDX_W-1:0]),
        .rd_data (rdata)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ready    <= 1'b0;
            addr_err <= 1'b0;
        end else begin
            ready    <= grant;
            addr_err <= eval && !in_range;
        end
    end

    AST_INIT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        init_en |=> !ready); // R9

    AST_RDATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !(eval && !we) |=> $stable(rdata)); // R7

    AST_ERR_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (eval && !in_range) |=> (addr_err && !ready)); // R8

    AST_READY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(ready && addr_err)); // R4

endmodule

// File: tb/wait_state_mem_tb.sv
module wait_state_mem_tb;
    localparam int MW = 64;
    localparam int AW = 8;
    localparam int DW = 16;
    localparam int IW = 6;

    typedef struct packed {
        logic          we;
        logic [AW-1:0] a;
        logic [DW-1:0] wd;
        logic [1:0]    wt;
        logic [DW-1:0] rd;
    } vec_t;

    // preload: word i holds 16'hA000 + i
    localparam vec_t VECS [12] = '{
        '{1'b0, 8'd1,  16'h0000, 2'd1, 16'hA001}, // first request new (R1)
        '{1'b0, 8'd0,  16'h0000, 2'd0, 16'hA000},
        '{1'b0, 8'd2,  16'h0000, 2'd2, 16'hA002},
        '{1'b1, 8'd5,  16'h1234, 2'd2, 16'h0000},
        '{1'b0, 8'd5,  16'h0000, 2'd2, 16'h1234}, // R6 read back
        '{1'b1, 8'd63, 16'hBEEF, 2'd0, 16'h0000},
        '{1'b0, 8'd63, 16'h0000, 2'd0, 16'hBEEF}, // R6 top word
        '{1'b0, 8'd4,  16'h0000, 2'd1, 16'hA004},
        '{1'b1, 8'd4,  16'h5555, 2'd1, 16'h0000}, // R3 direction change
        '{1'b1, 8'd4,  16'h6666, 2'd1, 16'h0000}, // R3 data change
        '{1'b0, 8'd4,  16'h0000, 2'd1, 16'h6666},
        '{1'b0, 8'd4,  16'h0000, 2'd0, 16'h6666}  // R3 repeat, no wait
    };

    logic          clk = 1'b0;
    logic          rst_n;
    logic          init_en;
    logic [IW-1:0] init_addr;
    logic [DW-1:0] init_data;
    logic          req, we;
    logic [AW-1:0] addr;
    logic [DW-1:0] wdata;
    logic          ready, addr_err;
    logic [DW-1:0] rdata;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    wait_state_mem #(.MEM_WORDS(MW), .ADDR_W(AW), .DATA_W(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .init_en(init_en), .init_addr(init_addr),
        .init_data(init_data), .req(req), .we(we), .addr(addr), .wdata(wdata),
        .ready(ready), .rdata(rdata), .addr_err(addr_err)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic count_waits(output int waits);
        waits = 0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (ready) break;
            waits++;
        end
    endtask

    task automatic run_req(input logic w, input logic [AW-1:0] a,
                           input logic [DW-1:0] d, output int waits);
        @(negedge clk);
        req = 1'b1; we = w; addr = a; wdata = d;
        count_waits(waits);
        req = 1'b0;
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog actual 0 expected 1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int w;
        rst_n = 1'b0; init_en = 1'b0; init_addr = '0; init_data = '0;
        req = 1'b0; we = 1'b0; addr = '0; wdata = '0;
        repeat (3) @(negedge clk);
        chk(ready == 1'b0, "R1 ready", ready, 0);
        chk(addr_err == 1'b0, "R1 addr_err", addr_err, 0);
        chk(rdata == '0, "R1 rdata", rdata, 0);
        rst_n = 1'b1;

        // preload while a request is held; it must be ignored (R9)
        req = 1'b1; we = 1'b0; addr = 8'd3;
        for (int i = 0; i < MW; i++) begin
            init_en = 1'b1; init_addr = IW'(i); init_data = DW'(16'hA000 + i);
            @(negedge clk);
            if (i % 16 == 5) chk(ready == 1'b0, "R9 req ignored", ready, 0);
        end
        init_en = 1'b0; req = 1'b0;

        for (int k = 0; k < 12; k++) begin
            run_req(VECS[k].we, VECS[k].a, VECS[k].wd, w);
            chk(w == int'(VECS[k].wt), "R2 wait count", w, VECS[k].wt);
            if (!VECS[k].we) chk(rdata == VECS[k].rd, "R5 rdata", rdata, VECS[k].rd);
        end

        // R4: held request completes every cycle
        @(negedge clk);
        req = 1'b1; we = 1'b0; addr = 8'd0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(ready == 1'b1, "R4 held ready", ready, 1);
        end
        chk(rdata == 16'hA000, "R5 held rdata", rdata, 16'hA000);
        req = 1'b0;
        @(negedge clk);
        chk(ready == 1'b0, "R10 idle ready", ready, 0);

        // R3: address change mid-wait restarts the countdown
        req = 1'b1; we = 1'b0; addr = 8'd2;
        @(negedge clk);
        chk(ready == 1'b0, "R2 stall", ready, 0);
        addr = 8'd5;
        count_waits(w);
        chk(w == 2, "R3 restart", w, 2);
        chk(rdata == 16'h1234, "R3 rdata", rdata, 16'h1234);
        req = 1'b0;

        // R10: pause keeps the remaining wait
        @(negedge clk);
        req = 1'b1; we = 1'b0; addr = 8'd8;
        @(negedge clk);
        req = 1'b0;
        @(negedge clk);
        chk(ready == 1'b0, "R10 paused", ready, 0);
        req = 1'b1;
        count_waits(w);
        chk(w == 1, "R10 resume", w, 1);
        chk(rdata == 16'hA008, "R10 rdata", rdata, 16'hA008);
        req = 1'b0;

        // R7: write and idle leave rdata alone
        run_req(1'b1, 8'd9, 16'h7777, w);
        chk(rdata == 16'hA008, "R7 after write", rdata, 16'hA008);
        repeat (2) @(negedge clk);
        chk(rdata == 16'hA008, "R7 after idle", rdata, 16'hA008);

        // R8: out-of-range write aliasing word 6
        req = 1'b1; we = 1'b1; addr = 8'd70; wdata = 16'hDEAD;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(addr_err == 1'b1, "R8 addr_err", addr_err, 1);
            chk(ready == 1'b0, "R8 no ready", ready, 0);
        end
        req = 1'b0;
        @(negedge clk);
        chk(addr_err == 1'b0, "R8 clears", addr_err, 0);
        run_req(1'b0, 8'd6, 16'h0000, w);
        chk(rdata == 16'hA006, "R8 store untouched", rdata, 16'hA006);
        run_req(1'b0, 8'd9, 16'h0000, w);
        chk(rdata == 16'h7777, "R6 write stored", rdata, 16'h7777);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule